// File: doc/BRIEF.md
# Segmented DAC Code Decoder

This block turns a 12-bit sample word into the switch-drive pattern of a segmented current-steering converter. The word's four upper bits become fifteen equal-weight thermometer lines. The next two bits each steer one binary-weighted source. The six lowest bits go straight to a ladder section.

The thermometer decode and a matching register on every other path all sit in one clocked alignment stage. The non-decoded bits and the latch enable therefore reach the output latch in the same cycle as the decoded lines. The output latch has an active-low enable. While the delayed enable is 0 it passes the aligned word, and while it is 1 it keeps the last pattern. Each steering line has a true and a complementary drive. A reconstructed code value and its complement are provided so the pattern can be compared with the input word.

Top module: `seg_dac_decoder`

## Requirements
- R1: Port `din[11]` is bit 1, the most significant bit, and `din[0]` is bit 12, the least significant. The thermometer section decodes `din[11:8]`. Thermometer line 8 (`therm_p[7]`) is asserted exactly when `din[11]` was 1.
- R2: Thermometer line k (k = 1..15, port bit `therm_p[k-1]`) is asserted exactly when the 4-bit value `din[11:8]` is at least k. The asserted lines are always a contiguous run starting at `therm_p[0]`.
- R3: `wgt_p[1]` carries bit 5 (`din[7]`, weight 128) and `wgt_p[0]` carries bit 6 (`din[6]`, weight 64). Neither bit affects any thermometer line.
- R4: `lad_p[5:0]` carries `din[5:0]` unchanged, with `lad_p[5]` being the most significant ladder bit.
- R5: While `latch_en_n` is 0, a word presented before a rising clock edge appears on all outputs right after that edge. The thermometer, weighted and ladder paths all have the same one-cycle latency.
- R6: The enable takes the same one-cycle delay as the data. If `latch_en_n` is 1 at a rising edge, every output keeps its value across that edge, whatever `din` does.
- R7: Every complementary output is the bitwise inverse of its true output: `therm_n = ~therm_p`, `wgt_n = ~wgt_p` and `lad_n = ~lad_p`.
- R8: `code_out` equals (number of asserted thermometer lines × 256) + `wgt_p[1]`×128 + `wgt_p[0]`×64 + `lad_p`. It therefore equals the latched word. `code_cmp_out` equals 4095 − `code_out`, so the two always sum to full scale minus one LSB. An all-ones word gives 4095 and 0.
- R9: A synchronous active-high `rst` clears the alignment stage and the latch to the zero code. After a reset edge, all true lines are 0, `code_out` is 0 and `code_cmp_out` is 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stage clock |
| rst | input | 1 | Synchronous active-high reset |
| latch_en_n | input | 1 | Output latch enable, 0 = transparent, 1 = hold |
| din | input | 12 | Sample word, din[11] is the MSB |
| therm_p | output | 15 | Thermometer segment drives, true side |
| therm_n | output | 15 | Thermometer segment drives, complementary side |
| wgt_p | output | 2 | Binary-weighted segment drives, true side |
| wgt_n | output | 2 | Binary-weighted segment drives, complementary side |
| lad_p | output | 6 | Ladder bit drives, true side |
| lad_n | output | 6 | Ladder bit drives, complementary side |
| code_out | output | 12 | Reconstructed code from the steering pattern |
| code_cmp_out | output | 12 | Complementary code, 4095 minus code_out |

## Verification
The bench walks every one of the 4096 codes in transparent mode. That sweep exposes a decoder that is off by one at a segment edge: a line would assert at k−1 or leave a gap. It also exposes a weighted or ladder bit taken from the wrong position, which shows up as a reconstructed code that differs from the word.

A second phase toggles the enable pseudo-randomly while the data keeps changing. An enable path that skipped the matching delay would latch the word one cycle early or late. The held output would then differ from the model at every hold edge. Reset in mid-stream, with the latch in both states, checks that no stale pattern survives.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
    localparam int WORD_W  = 12;
    localparam int MSB_W   = 4;
    localparam int MID_W   = 2;
    localparam int LSB_W   = 6;
    localparam int THERM_N = (1 << MSB_W) - 1;
    localparam int LOW_W   = MID_W + LSB_W;
    localparam int CNT_W   = MSB_W + 1;
    localparam logic [WORD_W-1:0] FULL_M1 = {WORD_W{1'b1}};

    typedef struct packed {
        logic [THERM_N-1:0] therm;
        logic [MID_W-1:0]   wgt;
        logic [LSB_W-1:0]   lad;
    } seg_word_t;

    localparam int SEG_W = $bits(seg_word_t);

    function automatic logic [CNT_W-1:0] therm_count(logic [THERM_N-1:0] t);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < THERM_N; i++) begin
            n = n + CNT_W'(t[i]);
        end
        return n;
    endfunction

    function automatic logic [WORD_W-1:0] seg_value(seg_word_t s);
        logic [WORD_W-1:0] v;
        v = WORD_W'(therm_count(s.therm)) << LOW_W;
        v = v + (WORD_W'(s.wgt) << LSB_W);
        v = v + WORD_W'(s.lad);
        return v;
    endfunction
endpackage

// File: rtl/seg_dac_therm_dec.sv
module seg_dac_therm_dec
    import seg_dac_pkg::*;
(
    input  logic [MSB_W-1:0]   msb_in,
    output logic [THERM_N-1:0] therm_out
);
    for (genvar k = 1; k <= THERM_N; k++) begin : g_line
        assign therm_out[k-1] = (msb_in >= MSB_W'(k));
    end
endmodule

// File: rtl/seg_dac_align.sv
module seg_dac_align
    import seg_dac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en_n_in,
    input  logic [THERM_N-1:0] therm_in,
    input  logic [MID_W-1:0]   wgt_in,
    input  logic [LSB_W-1:0]   lad_in,
    output seg_word_t          word_q,
    output logic               en_n_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            en_n_q <= 1'b1;
        end else begin
            word_q.therm <= therm_in;
            word_q.wgt   <= wgt_in;
            word_q.lad   <= lad_in;
            en_n_q       <= en_n_in;
        end
    end
endmodule

// File: rtl/seg_dac_hold.sv
module seg_dac_hold
    import seg_dac_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_n,
    input  seg_word_t d,
    output seg_word_t q
);
    seg_word_t held;

    always_comb begin
        q = en_n ? held : d;
    end

    always_ff @(posedge clk) begin
        if (rst) held <= '0;
        else     held <= q;
    end
endmodule

// File: rtl/seg_dac_steer.sv
module seg_dac_steer
    import seg_dac_pkg::*;
(
    input  seg_word_t          w,
    output logic [THERM_N-1:0] therm_p,
    output logic [THERM_N-1:0] therm_n,
    output logic [MID_W-1:0]   wgt_p,
    output logic [MID_W-1:0]   wgt_n,
    output logic [LSB_W-1:0]   lad_p,
    output logic [LSB_W-1:0]   lad_n,
    output logic [WORD_W-1:0]  code,
    output logic [WORD_W-1:0]  code_cmp
);
    always_comb begin
        therm_p  = w.therm;
        therm_n  = ~w.therm;
        wgt_p    = w.wgt;
        wgt_n    = ~w.wgt;
        lad_p    = w.lad;
        lad_n    = ~w.lad;
        code     = seg_value(w);
        code_cmp = FULL_M1 - code;
    end
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
    import seg_dac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               latch_en_n,
    input  logic [WORD_W-1:0]  din,
    output logic [THERM_N-1:0] therm_p,
    output logic [THERM_N-1:0] therm_n,
    output logic [MID_W-1:0]   wgt_p,
    output logic [MID_W-1:0]   wgt_n,
    output logic [LSB_W-1:0]   lad_p,
    output logic [LSB_W-1:0]   lad_n,
    output logic [WORD_W-1:0]  code_out,
    output logic [WORD_W-1:0]  code_cmp_out
);
    logic [THERM_N-1:0] therm_raw;
    seg_word_t          aligned;
    seg_word_t          latched;
    logic               en_n_dly;

    seg_dac_therm_dec u_dec (
        .msb_in    (din[WORD_W-1 -: MSB_W]),
        .therm_out (therm_raw)
    );

    seg_dac_align u_align (
        .clk      (clk),
        .rst      (rst),
        .en_n_in  (latch_en_n),
        .therm_in (therm_raw),
        .wgt_in   (din[LOW_W-1 -: MID_W]),
        .lad_in   (din[LSB_W-1:0]),
        .word_q   (aligned),
        .en_n_q   (en_n_dly)
    );

    seg_dac_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .en_n (en_n_dly),
        .d    (aligned),
        .q    (latched)
    );

    seg_dac_steer u_steer (
        .w        (latched),
        .therm_p  (therm_p),
        .therm_n  (therm_n),
        .wgt_p    (wgt_p),
        .wgt_n    (wgt_n),
        .lad_p    (lad_p),
        .lad_n    (lad_n),
        .code     (code_out),
        .code_cmp (code_cmp_out)
    );
endmodule

// File: rtl/seg_dac_decoder_chk.sv
module seg_dac_decoder_chk
    import seg_dac_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               latch_en_n,
    input logic [WORD_W-1:0]  din,
    input logic [THERM_N-1:0] therm_p,
    input logic [MID_W-1:0]   wgt_p,
    input logic [LSB_W-1:0]   lad_p,
    input logic [WORD_W-1:0]  code_out
);
    assert_msb_line_R1: assert property (@(posedge clk) disable iff (rst)
        !latch_en_n |=> therm_p[7] == $past(din[11]));

    assert_contiguous_R2: assert property (@(posedge clk) disable iff (rst)
        ((therm_p + 1'b1) & therm_p) == '0);

    assert_weighted_R3: assert property (@(posedge clk) disable iff (rst)
        !latch_en_n |=> wgt_p == $past(din[7:6]));

    assert_ladder_R4: assert property (@(posedge clk) disable iff (rst)
        !latch_en_n |=> lad_p == $past(din[5:0]));

    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        !latch_en_n |=> code_out == $past(din));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        latch_en_n |=> ($stable(code_out) && $stable(therm_p)));

    assert_count_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(therm_p) == int'(code_out[11:8]));
endmodule

bind seg_dac_decoder seg_dac_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .latch_en_n (latch_en_n),
    .din        (din),
    .therm_p    (therm_p),
    .wgt_p      (wgt_p),
    .lad_p      (lad_p),
    .code_out   (code_out)
);

// File: tb/tb_seg_dac_decoder.sv
`timescale 1ns/1ps
module tb_seg_dac_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        latch_en_n = 1'b0;
    logic [11:0] din = '0;
    logic [14:0] therm_p, therm_n;
    logic [1:0]  wgt_p, wgt_n;
    logic [5:0]  lad_p, lad_n;
    logic [11:0] code_out, code_cmp_out;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    int m_s1 = 0;
    int m_en = 1;
    int m_hold = 0;

    always #2.5 clk = ~clk;

    seg_dac_decoder dut (
        .clk(clk), .rst(rst), .latch_en_n(latch_en_n), .din(din),
        .therm_p(therm_p), .therm_n(therm_n), .wgt_p(wgt_p), .wgt_n(wgt_n),
        .lad_p(lad_p), .lad_n(lad_n), .code_out(code_out), .code_cmp_out(code_cmp_out)
    );

    function automatic int model_out();
        return (m_en != 0) ? m_hold : m_s1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 0; m_en = 1; m_hold = 0;
        end else begin
            m_hold = model_out();
            m_s1   = int'(din);
            m_en   = int'(latch_en_n);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int v, msb;
        logic [14:0] exp_t;
        v = model_out();
        msb = v >> 8;
        for (int k = 1; k <= 15; k++) exp_t[k-1] = (msb >= k);
        check(therm_p[7] == exp_t[7], "R1", int'(therm_p[7]), int'(exp_t[7]));
        check(therm_p == exp_t, "R2", int'(therm_p), int'(exp_t));
        check(wgt_p == 2'(v >> 6), "R3", int'(wgt_p), (v >> 6) & 3);
        check(lad_p == 6'(v), "R4", int'(lad_p), v & 63);
        check(therm_n == ~therm_p && wgt_n == ~wgt_p && lad_n == ~lad_p, "R7",
              int'({therm_n, wgt_n, lad_n}), int'(~{therm_p, wgt_p, lad_p}));
        check(int'(code_out) == v, "R8", int'(code_out), v);
        check(int'(code_out) + int'(code_cmp_out) == 4095, "R8",
              int'(code_out) + int'(code_cmp_out), 4095);
    endtask

    task automatic step(input logic [11:0] d, input logic en, input string req, input int exp_code);
        @(posedge clk); #1;
        din = d; latch_en_n = en;
        @(posedge clk); #1;
        check(int'(code_out) == exp_code, req, int'(code_out), exp_code);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(negedge clk) if (!rst && !done) compare_all();

    initial begin
        logic [11:0] held_v;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        check(therm_p == '0 && wgt_p == '0 && lad_p == '0, "R9", int'(therm_p), 0);
        check(code_out == 12'd0 && code_cmp_out == 12'd4095, "R9", int'(code_cmp_out), 4095);
        rst = 1'b0;
        // R5 sweep every code, transparent
        for (int c = 0; c < 4096; c++) begin
            @(posedge clk); #1;
            din = 12'(c); latch_en_n = 1'b0;
        end
        // R8 corner codes, R5 latency
        step(12'hFFF, 1'b0, "R8", 4095);
        check(code_cmp_out == 12'd0, "R8", int'(code_cmp_out), 0);
        step(12'h000, 1'b0, "R5", 0);
        step(12'h0C0, 1'b0, "R3", 192);
        check(therm_p == '0, "R3", int'(therm_p), 0);
        step(12'h800, 1'b0, "R1", 2048);
        // R6 hold: enable high while data changes
        step(12'hA5C, 1'b0, "R5", 12'hA5C);
        held_v = 12'hA5C;
        for (int i = 0; i < 8; i++) begin
            step(12'(i * 517 + 3), 1'b1, "R6", int'(held_v));
        end
        step(12'h123, 1'b0, "R6", 12'h123);
        // mixed pseudo-random enable and data
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            din = 12'($urandom);
            latch_en_n = ($urandom % 3) == 0;
        end
        // R9 reset mid-stream with latch holding
        @(posedge clk); #1;
        din = 12'hFFF; latch_en_n = 1'b0;
        @(posedge clk); #1;
        latch_en_n = 1'b1; rst = 1'b1;
        @(posedge clk); #1;
        check(code_out == 12'd0 && therm_p == '0, "R9", int'(code_out), 0);
        check(code_cmp_out == 12'd4095, "R9", int'(code_cmp_out), 4095);
        rst = 1'b0;
        step(12'h777, 1'b1, "R9", 0);
        step(12'h777, 1'b0, "R5", 12'h777);
        @(posedge clk); #1;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule